// File: doc/BRIEF.md
# Mailbox and Doorbell Messaging Unit

This block is a small register bank that lets a host and a local processor exchange short messages and wake each other up. It is reached through a single-beat memory-mapped slave port that both sides share; every request carries a flag saying which side issued it. Each direction has two 32-bit message registers and one 32-bit doorbell register. Storing a message latches a pending flag for that slot. Setting a doorbell bit leaves that bit pending until the receiving side clears it. Pending events are gathered into one status register per direction. Each status bit has its own mask bit, and each direction drives one interrupt line.

Inbound resources are aimed at the local processor and drive `irq_local`. Outbound resources are aimed at the host and drive `irq_host`. The bank claims a 4 KB window whose upper address bits sit in a base register inside that same window, so software can move the bank. Because reads may be used for handshaking, multi-beat accesses are never completed: they receive an error response and change nothing.

Top module: `mbox_msg_unit`

## Requirements
- R1: After reset every message, doorbell, status and mask register reads zero, both interrupt outputs are low and the base register holds `RESET_BASE` (default 0x8000_0000).
- R2: A request whose address bits [31:12] equal the base field is claimed and answered with `rsp_valid` high in the following cycle. Any other request gets no response and changes no state.
- R3: The message registers are at window offsets 0x00 and 0x04 (inbound slots 0 and 1) and at 0x08 and 0x0C (outbound slots 0 and 1). Each reads back the last 32-bit value written to it by either side.
- R4: A write to message slot k sets status bit k of its direction. The inbound status register is at offset 0x18 and the outbound status register is at 0x20.
- R5: The inbound doorbell is at offset 0x10 and the outbound doorbell is at 0x14. A write by the setting side (host, `req_src`=0, for inbound; local, `req_src`=1, for outbound) ORs the written ones into the doorbell. A write by the other side clears the doorbell bits written as one. Zero bits leave the doorbell unchanged.
- R6: Status bit 2 of a direction reads 1 exactly while that direction's doorbell is nonzero. Writes to status bit 2 have no effect.
- R7: Writing 1 to status bit 0 or bit 1 clears it. Writing 0 leaves it unchanged.
- R8: The mask registers are at offset 0x1C (inbound) and 0x24 (outbound), bits [2:0]. A mask bit of 1 blocks the status bit at the same position. Each interrupt output is the OR of its direction's unmasked status bits and follows a register change in the same cycle as the response.
- R9: A claimed request with `req_burst` high is answered with `rsp_err` high and read data zero, and leaves all state unchanged.
- R10: Any other offset in the window reads as zero without error and ignores writes.
- R11: The base register at offset 0x28 reads as the base field in bits [31:12] with zeros below. A write replaces the base field, and the window moves from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_src | input | 1 | Issuing side: 0 host, 1 local |
| req_burst | input | 1 | Request is part of a multi-beat transfer |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the claimed request of the previous cycle |
| rsp_err | output | 1 | Request refused as a burst |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| irq_local | output | 1 | Inbound interrupt toward the local processor |
| irq_host | output | 1 | Outbound interrupt toward the host |

## Verification
Every result of a request is registered once. The response fields and the effect on both interrupt lines are due right after the clock edge that samples the request. The bench drives each request on a falling edge, lets one rising edge pass, and samples all outputs one time unit later. At that point it compares them with a reference model that is updated only after the comparison. Because each request completes before the next one is driven, a read that follows a write always sees that write's effect, and the bench's expected values follow that order.

// File: rtl/mu_pkg.sv
package mu_pkg;

    typedef enum logic {
        SRC_HOST  = 1'b0,
        SRC_LOCAL = 1'b1
    } src_e;

    localparam int DIR_IN  = 0;
    localparam int DIR_OUT = 1;
    localparam int NUM_DIR = 2;

    typedef enum logic [2:0] {
        K_NONE,
        K_MSG,
        K_DOOR,
        K_STAT,
        K_MASK,
        K_BASE
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic       dir;
        logic [7:0] slot;
    } target_t;

    // Word layout: inbound msgs, outbound msgs, two doorbells,
    // (status, mask) per direction, then the base register.
    function automatic target_t map_word(int unsigned widx, int unsigned nmsg);
        target_t     t;
        int unsigned rel;
        t.kind = K_NONE;
        t.dir  = 1'b0;
        t.slot = '0;
        rel    = 0;
        if (widx < 2 * nmsg) begin
            t.kind = K_MSG;
            t.dir  = (widx >= nmsg);
            t.slot = 8'(widx % nmsg);
        end else if (widx < 2 * nmsg + 2) begin
            t.kind = K_DOOR;
            t.dir  = (widx == 2 * nmsg + 1);
        end else if (widx < 2 * nmsg + 6) begin
            rel    = widx - 2 * nmsg - 2;
            t.dir  = rel[1];
            t.kind = rel[0] ? K_MASK : K_STAT;
        end else if (widx == 2 * nmsg + 6) begin
            t.kind = K_BASE;
        end
        return t;
    endfunction

endpackage

// File: rtl/mu_decode.sv
module mu_decode
    import mu_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int WIN_LSB = 12,
    parameter int NUM_MSG = 2
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [ADDR_W-WIN_LSB-1:0] base_hi,
    output logic                      hit,
    output target_t                   tgt
);
    localparam int WIDX_W = WIN_LSB - 2;

    logic [WIDX_W-1:0] widx;
    logic [1:0]        unused_lsb;

    assign unused_lsb = addr[1:0];
    assign widx       = addr[WIN_LSB-1:2];
    assign hit        = (addr[ADDR_W-1:WIN_LSB] == base_hi);
    assign tgt        = map_word(32'(widx), NUM_MSG);
endmodule

// File: rtl/mu_dir.sv
module mu_dir #(
    parameter int DATA_W  = 32,
    parameter int NUM_MSG = 2,
    parameter int SLOT_W  = 1,
    parameter int STAT_W  = NUM_MSG + 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            msg_we,
    input  logic [SLOT_W-1:0]               msg_slot,
    input  logic                            door_we,
    input  logic                            stat_we,
    input  logic                            mask_we,
    input  logic                            setter,
    input  logic [DATA_W-1:0]               wdata,
    output logic [NUM_MSG-1:0][DATA_W-1:0]  msg_q,
    output logic [DATA_W-1:0]               door_q,
    output logic [STAT_W-1:0]               stat_q,
    output logic [STAT_W-1:0]               mask_q,
    output logic                            irq
);
    logic [NUM_MSG-1:0] flag_q;

    for (genvar k = 0; k < NUM_MSG; k++) begin : g_slot
        logic slot_hit;
        assign slot_hit = msg_we && (msg_slot == SLOT_W'(k));

        always_ff @(posedge clk) begin
            if (rst) begin
                msg_q[k] <= '0;
            end else if (slot_hit) begin
                msg_q[k] <= wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q[k] <= 1'b0;
            end else if (slot_hit) begin
                flag_q[k] <= 1'b1;
            end else if (stat_we && wdata[k]) begin
                flag_q[k] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            door_q <= '0;
        end else if (door_we) begin
            door_q <= setter ? (door_q | wdata) : (door_q & ~wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= wdata[STAT_W-1:0];
        end
    end

    assign stat_q = {(|door_q), flag_q};
    assign irq    = |(stat_q & ~mask_q);
endmodule

// File: rtl/mbox_msg_unit.sv
module mbox_msg_unit
    import mu_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter int                ADDR_W     = 32,
    parameter int                WIN_LSB    = 12,
    parameter int                NUM_MSG    = 2,
    parameter logic [ADDR_W-1:0] RESET_BASE = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_src,
    input  logic              req_burst,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              irq_local,
    output logic              irq_host
);
    localparam int SLOT_W = (NUM_MSG > 1) ? $clog2(NUM_MSG) : 1;
    localparam int STAT_W = NUM_MSG + 1;
    localparam int BASE_W = ADDR_W - WIN_LSB;

    logic [BASE_W-1:0]                             base_q;
    logic                                          win_hit;
    target_t                                       tgt;
    logic                                          claim;
    logic                                          do_wr;
    logic [SLOT_W-1:0]                             slot;
    logic [NUM_DIR-1:0][NUM_MSG-1:0][DATA_W-1:0]   msg_all;
    logic [NUM_DIR-1:0][DATA_W-1:0]                door_all;
    logic [NUM_DIR-1:0][STAT_W-1:0]                stat_all;
    logic [NUM_DIR-1:0][STAT_W-1:0]                mask_all;
    logic [NUM_DIR-1:0]                            irq_v;
    logic [DATA_W-1:0]                             rd_word;

    mu_decode #(
        .ADDR_W  (ADDR_W),
        .WIN_LSB (WIN_LSB),
        .NUM_MSG (NUM_MSG)
    ) u_dec (
        .addr    (req_addr),
        .base_hi (base_q),
        .hit     (win_hit),
        .tgt     (tgt)
    );

    assign claim = req_valid && win_hit;
    assign do_wr = claim && req_write && !req_burst;
    assign slot  = SLOT_W'(tgt.slot);

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        localparam src_e SETTER = (d == DIR_IN) ? SRC_HOST : SRC_LOCAL;
        logic sel_dir;
        assign sel_dir = (tgt.dir == 1'(d));

        mu_dir #(
            .DATA_W  (DATA_W),
            .NUM_MSG (NUM_MSG),
            .SLOT_W  (SLOT_W),
            .STAT_W  (STAT_W)
        ) u_dir (
            .clk      (clk),
            .rst      (rst),
            .msg_we   (do_wr && sel_dir && (tgt.kind == K_MSG)),
            .msg_slot (slot),
            .door_we  (do_wr && sel_dir && (tgt.kind == K_DOOR)),
            .stat_we  (do_wr && sel_dir && (tgt.kind == K_STAT)),
            .mask_we  (do_wr && sel_dir && (tgt.kind == K_MASK)),
            .setter   (req_src == SETTER),
            .wdata    (req_wdata),
            .msg_q    (msg_all[d]),
            .door_q   (door_all[d]),
            .stat_q   (stat_all[d]),
            .mask_q   (mask_all[d]),
            .irq      (irq_v[d])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= RESET_BASE[ADDR_W-1:WIN_LSB];
        end else if (do_wr && (tgt.kind == K_BASE)) begin
            base_q <= req_wdata[ADDR_W-1:WIN_LSB];
        end
    end

    always_comb begin
        rd_word = '0;
        unique case (tgt.kind)
            K_MSG:   rd_word = msg_all[tgt.dir][slot];
            K_DOOR:  rd_word = door_all[tgt.dir];
            K_STAT:  rd_word = DATA_W'(stat_all[tgt.dir]);
            K_MASK:  rd_word = DATA_W'(mask_all[tgt.dir]);
            K_BASE:  rd_word = DATA_W'({base_q, {WIN_LSB{1'b0}}});
            default: rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= claim;
            rsp_err   <= claim && req_burst;
            rsp_rdata <= (claim && !req_write && !req_burst) ? rd_word : '0;
        end
    end

    assign irq_local = irq_v[DIR_IN];
    assign irq_host  = irq_v[DIR_OUT];
endmodule

// File: rtl/mbox_msg_unit_chk.sv
module mbox_msg_unit_chk #(
    parameter int DATA_W = 32,
    parameter int STAT_W = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_write,
    input logic                req_burst,
    input logic                win_hit,
    input logic                rsp_valid,
    input logic                rsp_err,
    input logic [DATA_W-1:0]   rsp_rdata,
    input logic                irq_local,
    input logic                irq_host,
    input logic [2*STAT_W-1:0] stat_all,
    input logic [2*STAT_W-1:0] mask_all
);
    AST_MISS_SILENT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !win_hit) |=> !rsp_valid); // R2

    AST_HIT_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && win_hit) |=> rsp_valid); // R2

    AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        (req_valid && win_hit && req_write) |=> (rsp_rdata == '0)); // R3

    AST_BURST_ERR: assert property (@(posedge clk) disable iff (rst)
        (req_valid && win_hit && req_burst) |=> (rsp_err && rsp_rdata == '0)); // R9

    AST_BURST_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_burst) |=> ($stable(stat_all) && $stable(mask_all))); // R9

    AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_valid); // R9

    AST_IN_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (&mask_all[STAT_W-1:0]) |-> !irq_local); // R8

    AST_OUT_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (&mask_all[2*STAT_W-1:STAT_W]) |-> !irq_host); // R8
endmodule

bind mbox_msg_unit mbox_msg_unit_chk #(
    .DATA_W (DATA_W),
    .STAT_W (NUM_MSG + 1)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_burst (req_burst),
    .win_hit   (win_hit),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .irq_local (irq_local),
    .irq_host  (irq_host),
    .stat_all  (stat_all),
    .mask_all  (mask_all)
);

// File: tb/mbox_msg_unit_tb.sv
module mbox_msg_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_src = 1'b0;
    logic        req_burst = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;
    logic        irq_local;
    logic        irq_host;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // reference model
    logic [31:0] m_msg [4];
    logic [31:0] m_door [2];
    logic [1:0]  m_flag [2];
    logic [2:0]  m_mask [2];
    logic [19:0] m_base;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mbox_msg_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_src   (req_src),
        .req_burst (req_burst),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .irq_local (irq_local),
        .irq_host  (irq_host)
    );

    function automatic logic [2:0] stat_of(int d);
        return {(|m_door[d]), m_flag[d]};
    endfunction

    function automatic logic [31:0] exp_read(int w);
        case (w)
            0, 1, 2, 3: return m_msg[w];
            4:  return m_door[0];
            5:  return m_door[1];
            6:  return {29'd0, stat_of(0)};
            7:  return {29'd0, m_mask[0]};
            8:  return {29'd0, stat_of(1)};
            9:  return {29'd0, m_mask[1]};
            10: return {m_base, 12'd0};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic exp_irq(int d);
        return |(stat_of(d) & ~m_mask[d]);
    endfunction

    task automatic model_write(int w, logic src, logic [31:0] d);
        case (w)
            0, 1, 2, 3: begin
                m_msg[w] = d;
                m_flag[w / 2][w % 2] = 1'b1;
            end
            4: m_door[0] = (src == 1'b0) ? (m_door[0] | d) : (m_door[0] & ~d);
            5: m_door[1] = (src == 1'b1) ? (m_door[1] | d) : (m_door[1] & ~d);
            6: m_flag[0] = m_flag[0] & ~d[1:0];
            7: m_mask[0] = d[2:0];
            8: m_flag[1] = m_flag[1] & ~d[1:0];
            9: m_mask[1] = d[2:0];
            10: m_base = d[31:12];
            default: ;
        endcase
    endtask

    task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic acc(logic w, logic s, logic b, logic [31:0] a, logic [31:0] d, string rq);
        logic        hit;
        int          widx;
        logic [31:0] exp;
        hit  = (a[31:12] == m_base);
        widx = int'(a[11:2]);
        exp  = (hit && !w && !b) ? exp_read(widx) : 32'd0;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_src   = s;
        req_burst = b;
        req_addr  = a;
        req_wdata = d;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        chk(rsp_valid === hit, {rq, " rsp_valid"}, 32'(rsp_valid), 32'(hit));
        if (hit) begin
            chk(rsp_err === b, {rq, " rsp_err"}, 32'(rsp_err), 32'(b));
            chk(rsp_rdata === exp, {rq, " rdata"}, rsp_rdata, exp);
        end
        if (hit && w && !b) model_write(widx, s, d);
        chk(irq_local === exp_irq(0), {rq, " irq_local"}, 32'(irq_local), 32'(exp_irq(0)));
        chk(irq_host === exp_irq(1), {rq, " irq_host"}, 32'(irq_host), 32'(exp_irq(1)));
    endtask

    function automatic logic [31:0] wa(int w);
        return {m_base, 10'(w), 2'b00};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) m_msg[i] = '0;
        for (int i = 0; i < 2; i++) begin
            m_door[i] = '0;
            m_flag[i] = '0;
            m_mask[i] = '0;
        end
        m_base = 20'h80000;
        void'($urandom(32'd20240611));

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset contents
        for (int w = 0; w < 11; w++) acc(1'b0, 1'b0, 1'b0, wa(w), 32'd0, "R1");

        // R3 / R4 / R8: message write, read back, status, interrupt
        acc(1'b1, 1'b0, 1'b0, wa(0), 32'hA5A5_1234, "R3");
        acc(1'b0, 1'b1, 1'b0, wa(0), 32'd0, "R3");
        acc(1'b0, 1'b1, 1'b0, wa(6), 32'd0, "R4");
        acc(1'b1, 1'b1, 1'b0, wa(3), 32'h0BAD_F00D, "R4");
        acc(1'b0, 1'b0, 1'b0, wa(8), 32'd0, "R4");
        acc(1'b1, 1'b1, 1'b0, wa(7), 32'd1, "R8");
        acc(1'b1, 1'b0, 1'b0, wa(9), 32'h7, "R8");
        acc(1'b1, 1'b1, 1'b0, wa(7), 32'd0, "R8");

        // R7: write-one-to-clear
        acc(1'b1, 1'b1, 1'b0, wa(6), 32'd0, "R7");
        acc(1'b0, 1'b1, 1'b0, wa(6), 32'd0, "R7");
        acc(1'b1, 1'b1, 1'b0, wa(6), 32'd1, "R7");
        acc(1'b0, 1'b1, 1'b0, wa(6), 32'd0, "R7");

        // R5 / R6: doorbells
        acc(1'b1, 1'b0, 1'b0, wa(4), 32'h0000_0003, "R5");
        acc(1'b1, 1'b0, 1'b0, wa(4), 32'h0000_0000, "R5");
        acc(1'b0, 1'b1, 1'b0, wa(4), 32'd0, "R5");
        acc(1'b1, 1'b1, 1'b0, wa(6), 32'h4, "R6");
        acc(1'b0, 1'b1, 1'b0, wa(6), 32'd0, "R6");
        acc(1'b1, 1'b1, 1'b0, wa(4), 32'h0000_0001, "R5");
        acc(1'b1, 1'b1, 1'b0, wa(4), 32'h0000_0002, "R6");
        acc(1'b0, 1'b1, 1'b0, wa(6), 32'd0, "R6");
        acc(1'b1, 1'b0, 1'b0, wa(5), 32'h8000_0000, "R5");
        acc(1'b1, 1'b1, 1'b0, wa(5), 32'h8000_0001, "R5");
        acc(1'b0, 1'b0, 1'b0, wa(5), 32'd0, "R5");

        // R9: burst refused, no state change
        acc(1'b1, 1'b0, 1'b1, wa(1), 32'hFFFF_FFFF, "R9");
        acc(1'b0, 1'b0, 1'b1, wa(0), 32'd0, "R9");
        acc(1'b0, 1'b1, 1'b0, wa(1), 32'd0, "R9");

        // R10: unused offsets
        acc(1'b1, 1'b0, 1'b0, wa(64), 32'h1234_5678, "R10");
        acc(1'b0, 1'b0, 1'b0, wa(64), 32'd0, "R10");
        acc(1'b0, 1'b0, 1'b0, wa(1023), 32'd0, "R10");

        // R2: outside the window
        acc(1'b1, 1'b0, 1'b0, 32'h1000_0000, 32'hDEAD_BEEF, "R2");
        acc(1'b0, 1'b0, 1'b0, 32'h8000_1000, 32'd0, "R2");
        acc(1'b0, 1'b1, 1'b0, wa(0), 32'd0, "R2");

        // R11: relocation
        acc(1'b0, 1'b1, 1'b0, wa(10), 32'd0, "R11");
        acc(1'b1, 1'b1, 1'b0, wa(10), 32'h4000_2ABC, "R11");
        acc(1'b0, 1'b1, 1'b0, 32'h8000_0000, 32'd0, "R11");
        acc(1'b0, 1'b1, 1'b0, wa(10), 32'd0, "R11");
        acc(1'b0, 1'b1, 1'b0, wa(0), 32'd0, "R11");

        // random mix
        for (int i = 0; i < 600; i++) begin
            int          w;
            logic        wr;
            logic [31:0] a;
            w  = int'($urandom_range(0, 12));
            wr = 1'($urandom);
            if (w == 10) wr = 1'b0;
            a  = ($urandom % 16 == 0) ? {m_base ^ 20'h00011, 10'(w), 2'b00} : wa(w);
            acc(wr, 1'($urandom), ($urandom % 10) == 0, a,
                ($urandom % 4 == 0) ? 32'($urandom % 8) : $urandom, "R8");
        end

        finish_run();
    end
endmodule